// File: doc/BRIEF.md
# Dual-Slot Decode-Time Move Forwarding Network

This block resolves source operands for a two-slot, in-order pipeline in which register-copy and load-immediate instructions ("moves") finish in decode. A move's value is taken from its sign-extended 8-bit immediate or from its resolved register operand. That operand may itself be a value still in flight in a later stage. The value is then passed unchanged through the EX and MA stages to write-back. Because the value exists in decode, the instruction issued beside the move in the younger slot can consume it in the same cycle, so a move never causes a bubble and may sit in either issue slot.

Each slot has two source operands, A and B. For each one the network chooses, from highest to lowest priority: the same-cycle move result of the older slot, the EX-stage result, the MA-stage result, the WB-stage result, and finally register-file read data. Non-move results enter the pipe at EX from the external ALU result inputs. The block holds the EX, MA and WB pipeline registers, which carry the destination and value of each slot. It drives the write-back ports and resolves a same-destination collision in favour of the younger slot.

Top module: `mvf_fwd_net`

## Requirements
- R1: A valid move with `id_mv_imm`=1 produces its 8-bit immediate sign-extended to 32 bits (bit 7 copied into bits 31:8).
- R2: A valid move with `id_mv_imm`=0 produces the fully resolved operand A of its own slot, including any in-flight forwarding.
- R3: When slot 0 (bit 0 of every per-slot bus) holds a valid move with write enable and its destination equals a slot 1 source index, that slot 1 operand equals the slot 0 move value in the same cycle, above every other source.
- R4: A move in slot 1 is never forwarded to a slot 0 operand in the same cycle.
- R5: Below the same-cycle path, operand priority is EX, then MA, then WB, then register-file data. Within one stage, a slot 1 entry wins over a slot 0 entry with the same destination.
- R6: The EX-stage forwarded value of a slot is its carried move value if the entry is a move, otherwise that slot's `ex_alu_res`. This value is what MA receives.
- R7: A move value written at decode appears unchanged on `wb_data` with `wb_we` high three unstalled clock edges later, together with its destination on `wb_rd`.
- R8: When both WB entries write the same destination, `wb_we[0]` is low and `wb_we[1]` is high.
- R9: While `stall` is high, the EX, MA and WB registers keep their contents, so the write-back outputs and in-flight forwarded values do not change.
- R10: After `rst_n` (active low) is released, no stage holds a valid entry: `wb_we` is 0 and every operand equals its register-file data unless decode supplies a same-cycle move.
- R11: A decode entry with `id_vld`=0 or `id_wen`=0 neither forwards in the same cycle nor enters the pipe as a writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Global hold of all pipeline registers |
| id_vld | input | 2 | Per-slot decode entry valid |
| id_mv | input | 2 | Per-slot entry is a move |
| id_mv_imm | input | 2 | Move source: 1 immediate, 0 register operand A |
| id_imm | input | 2x8 | Per-slot immediate field |
| id_rsa | input | 2x4 | Per-slot operand A register index |
| id_rsb | input | 2x4 | Per-slot operand B register index |
| id_wen | input | 2 | Per-slot writes a destination |
| id_rd | input | 2x4 | Per-slot destination index |
| rf_rda | input | 2x32 | Register-file read data for operand A |
| rf_rdb | input | 2x32 | Register-file read data for operand B |
| ex_alu_res | input | 2x32 | ALU result of each EX-stage slot |
| opa | output | 2x32 | Resolved operand A per slot |
| opb | output | 2x32 | Resolved operand B per slot |
| wb_we | output | 2 | Write-back enable per slot |
| wb_rd | output | 2x4 | Write-back destination per slot |
| wb_data | output | 2x32 | Write-back value per slot |

## Verification
The assertions assume that decode fields and register-file data carry known values and that `stall` may rise or fall in any cycle. They also assume that the ALU result inputs are only meaningful for non-move EX entries. The stimulus draws most register indices from a four-register window, so that destinations collide across slots and stages and every priority level gets exercised. It mixes in full-range indices, random stall cycles and invalid or non-writing entries that still carry matching destinations. A few directed cycles cover immediates with bit 7 set, a slot 1 move aimed at a slot 0 source, and a write-back collision.

// File: rtl/mvf_pkg.sv
package mvf_pkg;
  // Which source drove a resolved operand, lowest priority first.
  typedef enum logic [2:0] {
    SRC_RF   = 3'd0,
    SRC_WB   = 3'd1,
    SRC_MA   = 3'd2,
    SRC_EX   = 3'd3,
    SRC_PAIR = 3'd4
  } fwd_src_e;

  localparam int unsigned NSLOT = 2;
endpackage

// File: rtl/mvf_opsel.sv
module mvf_opsel
  import mvf_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned RW       = 4,
  parameter bit          USE_PAIR = 1'b0
) (
  input  logic [RW-1:0]              rs,
  input  logic [XLEN-1:0]            rf_data,
  input  logic                       pair_fw,
  input  logic [RW-1:0]              pair_rd,
  input  logic [XLEN-1:0]            pair_val,
  input  logic [NSLOT-1:0]           ex_fw,
  input  logic [NSLOT-1:0][RW-1:0]   ex_rd,
  input  logic [NSLOT-1:0][XLEN-1:0] ex_val,
  input  logic [NSLOT-1:0]           ma_fw,
  input  logic [NSLOT-1:0][RW-1:0]   ma_rd,
  input  logic [NSLOT-1:0][XLEN-1:0] ma_val,
  input  logic [NSLOT-1:0]           wb_fw,
  input  logic [NSLOT-1:0][RW-1:0]   wb_rd,
  input  logic [NSLOT-1:0][XLEN-1:0] wb_val,
  output logic [XLEN-1:0]            val,
  output fwd_src_e                   src
);
  logic pair_hit;
  // Only the younger slot may see the older slot's decode-time move.
  assign pair_hit = USE_PAIR && pair_fw && (pair_rd == rs);

  // Sources are applied lowest priority first; later writes override.
  // Slot indices ascend so a slot 1 entry beats slot 0 in the same stage.
  always_comb begin
    val = rf_data;
    src = SRC_RF;
    for (int s = 0; s < NSLOT; s++) begin
      if (wb_fw[s] && (wb_rd[s] == rs)) begin
        val = wb_val[s];
        src = SRC_WB;
      end
    end
    for (int s = 0; s < NSLOT; s++) begin
      if (ma_fw[s] && (ma_rd[s] == rs)) begin
        val = ma_val[s];
        src = SRC_MA;
      end
    end
    for (int s = 0; s < NSLOT; s++) begin
      if (ex_fw[s] && (ex_rd[s] == rs)) begin
        val = ex_val[s];
        src = SRC_EX;
      end
    end
    if (pair_hit) begin
      val = pair_val;
      src = SRC_PAIR;
    end
  end
endmodule

// File: rtl/mvf_move_resolve.sv
module mvf_move_resolve #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IMMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld,
  input  logic            is_mv,
  input  logic            imm_sel,
  input  logic [IMMW-1:0] imm,
  input  logic [XLEN-1:0] opa,
  output logic [XLEN-1:0] mv_val
);
  localparam int unsigned EXTW = XLEN - IMMW;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
    return {{EXTW{v[IMMW-1]}}, v};
  endfunction

  logic use_imm;
  assign use_imm = vld && is_mv && imm_sel;
  assign mv_val  = imm_sel ? sext_imm(imm) : opa;

  // The upper part of an immediate move is all copies of its sign bit.
  assert_imm_sext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    use_imm |-> ((&mv_val[XLEN-1:IMMW-1]) || (~|mv_val[XLEN-1:IMMW-1])) &&
                (mv_val[IMMW-1:0] == imm));
endmodule

// File: rtl/mvf_pipe_stage.sv
module mvf_pipe_stage
  import mvf_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RW   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hold,
  input  logic [NSLOT-1:0]           d_fw,
  input  logic [NSLOT-1:0]           d_mv,
  input  logic [NSLOT-1:0][RW-1:0]   d_rd,
  input  logic [NSLOT-1:0][XLEN-1:0] d_val,
  output logic [NSLOT-1:0]           q_fw,
  output logic [NSLOT-1:0]           q_mv,
  output logic [NSLOT-1:0][RW-1:0]   q_rd,
  output logic [NSLOT-1:0][XLEN-1:0] q_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_fw  <= '0;
      q_mv  <= '0;
      q_rd  <= '0;
      q_val <= '0;
    end else if (!hold) begin
      q_fw  <= d_fw;
      q_mv  <= d_mv;
      q_rd  <= d_rd;
      q_val <= d_val;
    end
  end

  assert_stage_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(q_fw) && $stable(q_mv) && $stable(q_rd) && $stable(q_val)));
endmodule

// File: rtl/mvf_fwd_net.sv
module mvf_fwd_net
  import mvf_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned IMMW = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                stall,
  input  logic [1:0]                          id_vld,
  input  logic [1:0]                          id_mv,
  input  logic [1:0]                          id_mv_imm,
  input  logic [1:0][IMMW-1:0]                id_imm,
  input  logic [1:0][$clog2(NREG)-1:0]        id_rsa,
  input  logic [1:0][$clog2(NREG)-1:0]        id_rsb,
  input  logic [1:0]                          id_wen,
  input  logic [1:0][$clog2(NREG)-1:0]        id_rd,
  input  logic [1:0][XLEN-1:0]                rf_rda,
  input  logic [1:0][XLEN-1:0]                rf_rdb,
  input  logic [1:0][XLEN-1:0]                ex_alu_res,
  output logic [1:0][XLEN-1:0]                opa,
  output logic [1:0][XLEN-1:0]                opb,
  output logic [1:0]                          wb_we,
  output logic [1:0][$clog2(NREG)-1:0]        wb_rd,
  output logic [1:0][XLEN-1:0]                wb_data
);
  localparam int unsigned RW = $clog2(NREG);

  // Decode-side named events
  logic [NSLOT-1:0]           id_fw;
  logic [NSLOT-1:0]           id_mvq;
  logic [NSLOT-1:0][XLEN-1:0] mv_val;
  logic [NSLOT-1:0][XLEN-1:0] id_val;
  logic                       pair_fw;

  // Stage contents
  logic [NSLOT-1:0]           ex_fw, ma_fw, wb_fw;
  logic [NSLOT-1:0]           ex_mv, ma_mv, wb_mv;
  logic [NSLOT-1:0][RW-1:0]   ex_rd, ma_rd, wb_rdq;
  logic [NSLOT-1:0][XLEN-1:0] ex_val, ma_val, wb_val;
  logic [NSLOT-1:0][XLEN-1:0] ex_fval;

  fwd_src_e [NSLOT-1:0]       src_a, src_b;

  assign id_fw   = id_vld & id_wen;
  assign id_mvq  = id_vld & id_mv;
  assign pair_fw = id_vld[0] && id_mv[0] && id_wen[0];

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      mvf_opsel #(.XLEN(XLEN), .RW(RW), .USE_PAIR(s != 0)) u_sel_a (
        .rs(id_rsa[s]), .rf_data(rf_rda[s]),
        .pair_fw(pair_fw), .pair_rd(id_rd[0]), .pair_val(mv_val[0]),
        .ex_fw(ex_fw), .ex_rd(ex_rd), .ex_val(ex_fval),
        .ma_fw(ma_fw), .ma_rd(ma_rd), .ma_val(ma_val),
        .wb_fw(wb_fw), .wb_rd(wb_rdq), .wb_val(wb_val),
        .val(opa[s]), .src(src_a[s]));

      mvf_opsel #(.XLEN(XLEN), .RW(RW), .USE_PAIR(s != 0)) u_sel_b (
        .rs(id_rsb[s]), .rf_data(rf_rdb[s]),
        .pair_fw(pair_fw), .pair_rd(id_rd[0]), .pair_val(mv_val[0]),
        .ex_fw(ex_fw), .ex_rd(ex_rd), .ex_val(ex_fval),
        .ma_fw(ma_fw), .ma_rd(ma_rd), .ma_val(ma_val),
        .wb_fw(wb_fw), .wb_rd(wb_rdq), .wb_val(wb_val),
        .val(opb[s]), .src(src_b[s]));

      mvf_move_resolve #(.XLEN(XLEN), .IMMW(IMMW)) u_mv (
        .clk(clk), .rst_n(rst_n),
        .vld(id_vld[s]), .is_mv(id_mv[s]), .imm_sel(id_mv_imm[s]),
        .imm(id_imm[s]), .opa(opa[s]), .mv_val(mv_val[s]));

      assign id_val[s]  = id_mvq[s] ? mv_val[s] : '0;
      // Non-move results become available from the ALU during EX.
      assign ex_fval[s] = ex_mv[s] ? ex_val[s] : ex_alu_res[s];

      // A move leaving decode lands in EX with its value untouched.
      assert_mv_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && id_fw[s] && id_mvq[s]) |=> (ex_fw[s] && ex_mv[s] &&
                                               ex_val[s] == $past(mv_val[s])));

      // An operand drawn from no in-flight source is the register-file data.
      assert_rf_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a[s] == SRC_RF) |-> (opa[s] == rf_rda[s]));

      // Invalid or non-writing decode entries never enter the pipe as writers.
      assert_no_ghost_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !id_fw[s]) |=> !ex_fw[s]);
    end
  endgenerate

  mvf_pipe_stage #(.XLEN(XLEN), .RW(RW)) u_ex (
    .clk(clk), .rst_n(rst_n), .hold(stall),
    .d_fw(id_fw), .d_mv(id_mvq), .d_rd(id_rd), .d_val(id_val),
    .q_fw(ex_fw), .q_mv(ex_mv), .q_rd(ex_rd), .q_val(ex_val));

  mvf_pipe_stage #(.XLEN(XLEN), .RW(RW)) u_ma (
    .clk(clk), .rst_n(rst_n), .hold(stall),
    .d_fw(ex_fw), .d_mv(ex_mv), .d_rd(ex_rd), .d_val(ex_fval),
    .q_fw(ma_fw), .q_mv(ma_mv), .q_rd(ma_rd), .q_val(ma_val));

  mvf_pipe_stage #(.XLEN(XLEN), .RW(RW)) u_wb (
    .clk(clk), .rst_n(rst_n), .hold(stall),
    .d_fw(ma_fw), .d_mv(ma_mv), .d_rd(ma_rd), .d_val(ma_val),
    .q_fw(wb_fw), .q_mv(wb_mv), .q_rd(wb_rdq), .q_val(wb_val));

  // The younger slot owns a shared destination at commit.
  logic wb_clash;
  assign wb_clash   = wb_fw[1] && wb_fw[0] && (wb_rdq[1] == wb_rdq[0]);
  assign wb_we[0]   = wb_fw[0] && !wb_clash;
  assign wb_we[1]   = wb_fw[1];
  assign wb_rd      = wb_rdq;
  assign wb_data    = wb_val;

  assert_wb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we[0] && wb_we[1]) |-> (wb_rd[0] != wb_rd[1]));

  assert_pair_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_fw && id_rd[0] == id_rsa[1]) |-> (opa[1] == mv_val[0]));

  // Slot 0 never takes the same-cycle path, whatever slot 1 decodes.
  assert_old_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a[0] != SRC_PAIR) && (src_b[0] != SRC_PAIR));

  assert_move_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && ma_fw[1] && ma_mv[1]) |=> (wb_we[1] && wb_data[1] == $past(ma_val[1])));

  assert_src_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b[1] == SRC_RF) |-> (opb[1] == rf_rdb[1]));

  assert_wb_mv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_mv[0] && !wb_fw[0]) |-> !wb_we[0]);
endmodule

// File: tb/mvf_fwd_net_bench.sv
`timescale 1ns/1ps
module mvf_fwd_net_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall;
  logic [1:0] id_vld, id_mv, id_mv_imm, id_wen;
  logic [1:0][7:0] id_imm;
  logic [1:0][3:0] id_rsa, id_rsb, id_rd;
  logic [1:0][31:0] rf_rda, rf_rdb, ex_alu_res;
  logic [1:0][31:0] opa, opb, wb_data;
  logic [1:0] wb_we;
  logic [1:0][3:0] wb_rd;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mvf_fwd_net u_mvf_fwd_net (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .id_vld(id_vld), .id_mv(id_mv), .id_mv_imm(id_mv_imm), .id_imm(id_imm),
    .id_rsa(id_rsa), .id_rsb(id_rsb), .id_wen(id_wen), .id_rd(id_rd),
    .rf_rda(rf_rda), .rf_rdb(rf_rdb), .ex_alu_res(ex_alu_res),
    .opa(opa), .opb(opb), .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data));

  // Bench model of the three stages: index 0 = EX, 1 = MA, 2 = WB
  bit          m_fw [3][2];
  bit          m_mv [3][2];
  logic [3:0]  m_rd [3][2];
  logic [31:0] m_val[3][2];

  function automatic logic [31:0] widen(input logic [7:0] v);
    logic [31:0] r;
    r = {24'd0, v};
    if (v[7]) r = r | 32'hFFFF_FF00;
    return r;
  endfunction

  function automatic logic [31:0] stage_val(input int st, input int sl);
    if (st == 0 && !m_mv[0][sl]) return ex_alu_res[sl];
    return m_val[st][sl];
  endfunction

  // Expected operand: highest priority checked first.
  function automatic logic [31:0] want_op(input int slot, input logic [3:0] rs,
                                          input logic [31:0] rf, input logic [31:0] pair_v,
                                          output string tag);
    if (slot == 1 && id_vld[0] && id_mv[0] && id_wen[0] && id_rd[0] == rs) begin
      tag = id_mv_imm[0] ? "R3 R1" : "R3 R2";
      return pair_v;
    end
    tag = "R5";
    if (slot == 0 && id_vld[1] && id_mv[1] && id_wen[1] && id_rd[1] == rs) tag = "R4";
    if (slot == 1 && id_mv[0] && id_rd[0] == rs && !(id_vld[0] && id_wen[0])) tag = "R11";
    for (int st = 0; st < 3; st++) begin
      if (m_fw[st][1] && m_rd[st][1] == rs) begin
        if (st == 0) tag = "R6";
        return stage_val(st, 1);
      end
      if (m_fw[st][0] && m_rd[st][0] == rs) begin
        if (st == 0) tag = "R6";
        return stage_val(st, 0);
      end
    end
    return rf;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    string t;
    logic [31:0] a0, b0, a1, b1, mv0, mv1;
    bit exp_we0, exp_we1;
    bit n_fw [3][2];
    bit n_mv [3][2];
    logic [3:0] n_rd [3][2];
    logic [31:0] n_val [3][2];
    string wtag;
    #1;
    a0 = want_op(0, id_rsa[0], rf_rda[0], 32'd0, t);
    chk(t, opa[0], a0, "opa0");
    b0 = want_op(0, id_rsb[0], rf_rdb[0], 32'd0, t);
    chk(t, opb[0], b0, "opb0");
    mv0 = id_mv_imm[0] ? widen(id_imm[0]) : a0;
    a1 = want_op(1, id_rsa[1], rf_rda[1], mv0, t);
    chk(t, opa[1], a1, "opa1");
    b1 = want_op(1, id_rsb[1], rf_rdb[1], mv0, t);
    chk(t, opb[1], b1, "opb1");
    mv1 = id_mv_imm[1] ? widen(id_imm[1]) : a1;

    wtag = stall ? "R9" : "R7";
    exp_we1 = m_fw[2][1];
    exp_we0 = m_fw[2][0] && !(m_fw[2][1] && m_rd[2][1] == m_rd[2][0]);
    chk((m_fw[2][0] && !exp_we0) ? "R8" : wtag, {31'd0, wb_we[0]}, {31'd0, exp_we0}, "wb_we0");
    chk(wtag, {31'd0, wb_we[1]}, {31'd0, exp_we1}, "wb_we1");
    for (int s = 0; s < 2; s++) begin
      if (m_fw[2][s]) begin
        chk(wtag, wb_data[s], m_val[2][s], "wb_data");
        chk(wtag, {28'd0, wb_rd[s]}, {28'd0, m_rd[2][s]}, "wb_rd");
      end
    end

    for (int s = 0; s < 2; s++) begin
      n_fw[0][s] = id_vld[s] && id_wen[s];
      n_mv[0][s] = id_vld[s] && id_mv[s];
      n_rd[0][s] = id_rd[s];
      n_val[0][s] = n_mv[0][s] ? ((s == 0) ? mv0 : mv1) : 32'd0;
      n_fw[1][s] = m_fw[0][s]; n_mv[1][s] = m_mv[0][s];
      n_rd[1][s] = m_rd[0][s]; n_val[1][s] = stage_val(0, s);
      n_fw[2][s] = m_fw[1][s]; n_mv[2][s] = m_mv[1][s];
      n_rd[2][s] = m_rd[1][s]; n_val[2][s] = m_val[1][s];
    end
    @(posedge clk);
    if (!stall) begin
      for (int st = 0; st < 3; st++)
        for (int s = 0; s < 2; s++) begin
          m_fw[st][s] = n_fw[st][s]; m_mv[st][s] = n_mv[st][s];
          m_rd[st][s] = n_rd[st][s]; m_val[st][s] = n_val[st][s];
        end
    end
    #2;
  endtask

  task automatic idle_inputs();
    stall = 1'b0;
    id_vld = '0; id_mv = '0; id_mv_imm = '0; id_wen = '0;
    id_imm = '0; id_rsa = '0; id_rsb = '0; id_rd = '0;
    rf_rda = {32'h1111_0000, 32'h0000_1111};
    rf_rdb = {32'h2222_0000, 32'h0000_2222};
    ex_alu_res = {32'hA1A1_0001, 32'hA0A0_0000};
  endtask

  task automatic rand_inputs();
    bit wide;
    wide = ($urandom % 5) == 0;
    stall = ($urandom % 10) == 0;
    for (int s = 0; s < 2; s++) begin
      id_vld[s]    = ($urandom % 8) != 0;
      id_mv[s]     = $urandom % 2;
      id_mv_imm[s] = $urandom % 2;
      id_wen[s]    = ($urandom % 6) != 0;
      id_imm[s]    = 8'($urandom);
      id_rsa[s]    = wide ? 4'($urandom) : 4'($urandom % 4);
      id_rsb[s]    = wide ? 4'($urandom) : 4'($urandom % 4);
      id_rd[s]     = wide ? 4'($urandom) : 4'($urandom % 4);
      rf_rda[s]    = $urandom;
      rf_rdb[s]    = $urandom;
      ex_alu_res[s] = $urandom;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int st = 0; st < 3; st++)
      for (int s = 0; s < 2; s++) begin
        m_fw[st][s] = 1'b0; m_mv[st][s] = 1'b0; m_rd[st][s] = '0; m_val[st][s] = '0;
      end
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R10: empty pipe after reset; operands come from register-file data
    step();

    // R1 and R3: slot 0 immediate move with bit 7 set, slot 1 reads it
    id_vld = 2'b11; id_mv = 2'b01; id_mv_imm = 2'b01; id_wen = 2'b11;
    id_imm[0] = 8'h80; id_rd[0] = 4'd2; id_rsa[1] = 4'd2; id_rsb[1] = 4'd2;
    id_rd[1] = 4'd7;
    step();
    // R4: slot 1 move targets a slot 0 source
    idle_inputs();
    id_vld = 2'b11; id_mv = 2'b10; id_mv_imm = 2'b10; id_wen = 2'b11;
    id_imm[1] = 8'h3C; id_rd[1] = 4'd5; id_rsa[0] = 4'd5; id_rd[0] = 4'd9;
    step();
    // R2: register move of r2 (now in MA) from slot 0, consumed by slot 1
    idle_inputs();
    id_vld = 2'b11; id_mv = 2'b01; id_wen = 2'b01; id_rsa[0] = 4'd2;
    id_rd[0] = 4'd11; id_rsa[1] = 4'd11;
    step();
    // R8: both slots write r12; they reach WB three edges later
    idle_inputs();
    id_vld = 2'b11; id_mv = 2'b11; id_mv_imm = 2'b11; id_wen = 2'b11;
    id_imm = {8'h12, 8'h34}; id_rd = {4'd12, 4'd12};
    step();
    idle_inputs();
    step();
    stall = 1'b1;  // R9: hold for two cycles
    step();
    step();
    stall = 1'b0;
    step();
    step();

    for (int n = 0; n < 4000; n++) begin
      rand_inputs();
      step();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule